// File: doc/BRIEF.md
# Leaf Page Permission Checker

This block sits after a page-table walker. When the walker reaches a final (leaf) translation entry, it presents the 64-bit entry together with three attributes of the access that caused the walk: whether the access runs in privileged mode, whether it is an instruction fetch, and whether it is a store. The block decides whether the access may go ahead. If it may, the block raises a go indication so that a translation cache entry can be loaded. If it may not, the block reports either a permission fault or a reference/change fault.

The decision is taken in the cycle of the request and registered once. A one-cycle ready pulse marks the cycle in which the result first appears. The three result flags then hold their values until the next request, and reset clears them. A permission fault always takes precedence over a reference/change fault, so at most one of the three result flags is set. An instruction fetch from a page marked cache-inhibited is refused even when the page allows execution.

Top module: `leaf_perm_chk`

## Requirements
- R1: After reset, `rdy_o`, `go_o`, `perm_fault_o` and `rc_fault_o` are all 0.
- R2: A request sampled on `req_i` at a rising edge raises `rdy_o` for exactly the following cycle, and the new result flags appear in that same cycle.
- R3: If entry bit 62 (leaf) is 0, the result has `go_o`, `perm_fault_o` and `rc_fault_o` all 0.
- R4: If entry bit 3 (privileged-only) is 1 and `priv_i` is 0, permission is refused and `perm_fault_o` is 1.
- R5: For a data access (`ifetch_i`=0), permission is granted when entry bit 1 (write) is 1, or when entry bit 2 (read) is 1 and `store_i` is 0. Otherwise `perm_fault_o` is 1.
- R6: For an instruction fetch (`ifetch_i`=1), permission is granted only when entry bit 0 (execute) is 1 and entry bit 5 (cache-inhibited) is 0. Otherwise `perm_fault_o` is 1.
- R7: The reference/change check passes when entry bit 8 (referenced) is 1 and, for a store, entry bit 7 (changed) is also 1. If permission passes and this check fails, `rc_fault_o` is 1.
- R8: When permission fails, `rc_fault_o` is 0 even if the reference/change check also fails. At most one of `go_o`, `perm_fault_o` and `rc_fault_o` is 1 at any time.
- R9: When the leaf bit is 1 and both checks pass, `go_o` is 1 and both fault flags are 0.
- R10: While `req_i` is 0, `go_o`, `perm_fault_o` and `rc_fault_o` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Check request, sampled at one edge |
| pte_i | input | 64 | Leaf translation entry under test |
| priv_i | input | 1 | Access is privileged |
| ifetch_i | input | 1 | Access is an instruction fetch |
| store_i | input | 1 | Access is a store |
| rdy_o | output | 1 | Result ready pulse, one cycle |
| go_o | output | 1 | Access allowed, load translation entry |
| perm_fault_o | output | 1 | Permission fault |
| rc_fault_o | output | 1 | Reference/change fault |

## Verification
The properties assume that the walker never marks a fetch as a store, so `store_i` is 0 whenever `ifetch_i` is 1. They also assume that `req_i` is held low during reset. The directed tasks drive every fetch with `store_i` low and keep `req_i` low until reset is released. The idle-hold scenario changes `pte_i`, `priv_i`, `ifetch_i` and `store_i` freely while `req_i` is low, because the block must ignore them at those times.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    // Registered outcome of one check
    typedef struct packed {
        logic rdy;
        logic go;
        logic perm_fault;
        logic rc_fault;
    } lpc_res_t;

    // Attributes of the access being checked
    typedef struct packed {
        logic priv;
        logic ifetch;
        logic store;
    } lpc_acc_t;

endpackage

// File: rtl/lpc_perm_eval.sv
module lpc_perm_eval
    import lpc_pkg::*;
#(
    parameter int PTE_W    = 64,
    parameter int X_BIT    = 0,
    parameter int W_BIT    = 1,
    parameter int R_BIT    = 2,
    parameter int PRIV_BIT = 3,
    parameter int CI_BIT   = 5
) (
    input  logic [PTE_W-1:0] pte_i,
    input  lpc_acc_t         acc_i,
    output logic             perm_ok_o
);

    logic mode_ok;
    logic data_ok;
    logic exec_ok;

    always_comb begin
        // user mode may not touch privileged-only pages
        mode_ok   = acc_i.priv | ~pte_i[PRIV_BIT];
        data_ok   = pte_i[W_BIT] | (pte_i[R_BIT] & ~acc_i.store);
        // a cache-inhibited page never yields instructions
        exec_ok   = pte_i[X_BIT] & ~pte_i[CI_BIT];
        perm_ok_o = mode_ok & (acc_i.ifetch ? exec_ok : data_ok);
    end

endmodule

// File: rtl/lpc_rc_eval.sv
module lpc_rc_eval
    import lpc_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int REF_BIT = 8,
    parameter int CHG_BIT = 7
) (
    input  logic [PTE_W-1:0] pte_i,
    input  lpc_acc_t         acc_i,
    output logic             rc_ok_o
);

    always_comb begin
        rc_ok_o = pte_i[REF_BIT] & (pte_i[CHG_BIT] | ~acc_i.store);
    end

endmodule

// File: rtl/leaf_perm_chk.sv
module leaf_perm_chk
    import lpc_pkg::*;
#(
    parameter int PTE_W    = 64,
    parameter int LEAF_BIT = 62,
    parameter int X_BIT    = 0,
    parameter int W_BIT    = 1,
    parameter int R_BIT    = 2,
    parameter int PRIV_BIT = 3,
    parameter int CI_BIT   = 5,
    parameter int CHG_BIT  = 7,
    parameter int REF_BIT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [PTE_W-1:0] pte_i,
    input  logic             priv_i,
    input  logic             ifetch_i,
    input  logic             store_i,
    output logic             rdy_o,
    output logic             go_o,
    output logic             perm_fault_o,
    output logic             rc_fault_o
);

    // Entry bits this block actually decodes
    localparam logic [PTE_W-1:0] USED_MASK =
        (PTE_W'(1) << LEAF_BIT) | (PTE_W'(1) << X_BIT) | (PTE_W'(1) << W_BIT) |
        (PTE_W'(1) << R_BIT)    | (PTE_W'(1) << PRIV_BIT) | (PTE_W'(1) << CI_BIT) |
        (PTE_W'(1) << CHG_BIT)  | (PTE_W'(1) << REF_BIT);

    lpc_acc_t acc;
    logic     perm_ok;
    logic     rc_ok;
    logic     is_leaf;
    logic     unused_pte;
    lpc_res_t res_d;
    lpc_res_t res_q;

    assign acc        = '{priv: priv_i, ifetch: ifetch_i, store: store_i};
    assign is_leaf    = pte_i[LEAF_BIT];
    assign unused_pte = ^(pte_i & ~USED_MASK);

    lpc_perm_eval #(
        .PTE_W    (PTE_W),
        .X_BIT    (X_BIT),
        .W_BIT    (W_BIT),
        .R_BIT    (R_BIT),
        .PRIV_BIT (PRIV_BIT),
        .CI_BIT   (CI_BIT)
    ) u_perm (
        .pte_i     (pte_i),
        .acc_i     (acc),
        .perm_ok_o (perm_ok)
    );

    lpc_rc_eval #(
        .PTE_W   (PTE_W),
        .REF_BIT (REF_BIT),
        .CHG_BIT (CHG_BIT)
    ) u_rc (
        .pte_i   (pte_i),
        .acc_i   (acc),
        .rc_ok_o (rc_ok)
    );

    always_comb begin
        res_d     = res_q;
        res_d.rdy = 1'b0;
        if (req_i) begin
            res_d.rdy        = 1'b1;
            res_d.go         = is_leaf & perm_ok & rc_ok;
            res_d.perm_fault = is_leaf & ~perm_ok;
            // permission failure masks a reference/change failure
            res_d.rc_fault   = is_leaf & perm_ok & ~rc_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rdy_o        = res_q.rdy;
    assign go_o         = res_q.go;
    assign perm_fault_o = res_q.perm_fault;
    assign rc_fault_o   = res_q.rc_fault;

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
    parameter int PTE_W    = 64,
    parameter int LEAF_BIT = 62,
    parameter int CI_BIT   = 5,
    parameter int X_BIT    = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [PTE_W-1:0] pte_i,
    input logic             ifetch_i,
    input logic             rdy_o,
    input logic             go_o,
    input logic             perm_fault_o,
    input logic             rc_fault_o
);

    // R2
    rdy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rdy_o);

    // R2
    rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(req_i));

    // R3
    nonleaf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !pte_i[LEAF_BIT]) |=> (!go_o && !perm_fault_o && !rc_fault_o));

    // R6
    ci_fetch_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ifetch_i && pte_i[LEAF_BIT] && pte_i[CI_BIT]) |=> (perm_fault_o && !go_o));

    // R6
    noexec_fetch_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ifetch_i && pte_i[LEAF_BIT] && !pte_i[X_BIT]) |=> perm_fault_o);

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_o, perm_fault_o, rc_fault_o}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable({go_o, perm_fault_o, rc_fault_o}));

endmodule

bind leaf_perm_chk lpc_checker #(
    .PTE_W    (PTE_W),
    .LEAF_BIT (LEAF_BIT),
    .CI_BIT   (CI_BIT),
    .X_BIT    (X_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .pte_i        (pte_i),
    .ifetch_i     (ifetch_i),
    .rdy_o        (rdy_o),
    .go_o         (go_o),
    .perm_fault_o (perm_fault_o),
    .rc_fault_o   (rc_fault_o)
);

// File: tb/leaf_perm_chk_tb.sv
module leaf_perm_chk_tb;

    localparam logic [63:0] LEAF = 64'h4000_0000_0000_0000;
    localparam logic [63:0] PX   = 64'h001;
    localparam logic [63:0] PW   = 64'h002;
    localparam logic [63:0] PR   = 64'h004;
    localparam logic [63:0] PP   = 64'h008;
    localparam logic [63:0] PCI  = 64'h020;
    localparam logic [63:0] PC   = 64'h080;
    localparam logic [63:0] PREF = 64'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [63:0] pte_i = '0;
    logic        priv_i = 1'b0;
    logic        ifetch_i = 1'b0;
    logic        store_i = 1'b0;
    logic        rdy_o, go_o, perm_fault_o, rc_fault_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    leaf_perm_chk u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .pte_i        (pte_i),
        .priv_i       (priv_i),
        .ifetch_i     (ifetch_i),
        .store_i      (store_i),
        .rdy_o        (rdy_o),
        .go_o         (go_o),
        .perm_fault_o (perm_fault_o),
        .rc_fault_o   (rc_fault_o)
    );

    task automatic expect4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rdy,go,perm,rc} actual %b expected %b", tag, act, exp);
        end
    endtask

    // One request; checks the ready cycle and the pulse end
    task automatic run_check(input string tag, input logic [63:0] pte, input logic pv,
                             input logic fe, input logic st,
                             input logic e_go, input logic e_pf, input logic e_rc);
        @(negedge clk);
        req_i = 1'b1; pte_i = pte; priv_i = pv; ifetch_i = fe; store_i = st;
        @(negedge clk);
        req_i = 1'b0;
        expect4(tag, {rdy_o, go_o, perm_fault_o, rc_fault_o}, {1'b1, e_go, e_pf, e_rc});
        @(negedge clk);
        expect4({tag, " R2 pulse end"}, {rdy_o, go_o, perm_fault_o, rc_fault_o},
                {1'b0, e_go, e_pf, e_rc});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect4("R1 reset", {rdy_o, go_o, perm_fault_o, rc_fault_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        expect4("R1 after release", {rdy_o, go_o, perm_fault_o, rc_fault_o}, 4'b0000);
    endtask

    task automatic t_nonleaf();
        run_check("R3 nonleaf full perms", PX|PW|PR|PREF|PC, 1, 0, 1, 0, 0, 0);
        run_check("R3 nonleaf no perms", PREF, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_priv();
        run_check("R4 user on priv page", LEAF|PP|PW|PREF|PC, 0, 0, 1, 0, 1, 0);
        run_check("R4 priv on priv page", LEAF|PP|PW|PREF|PC, 1, 0, 1, 1, 0, 0);
        run_check("R4 user fetch priv page", LEAF|PP|PX|PREF, 0, 1, 0, 0, 1, 0);
    endtask

    task automatic t_data();
        run_check("R5 load read-only", LEAF|PR|PREF, 0, 0, 0, 1, 0, 0);
        run_check("R5 store read-only", LEAF|PR|PREF|PC, 0, 0, 1, 0, 1, 0);
        run_check("R5 store writable", LEAF|PW|PREF|PC, 0, 0, 1, 1, 0, 0);
        run_check("R5 load write-only", LEAF|PW|PREF, 0, 0, 0, 1, 0, 0);
        run_check("R5 load exec-only", LEAF|PX|PREF, 1, 0, 0, 0, 1, 0);
    endtask

    task automatic t_fetch();
        run_check("R6 fetch exec", LEAF|PX|PREF, 0, 1, 0, 1, 0, 0);
        run_check("R6 fetch exec CI", LEAF|PX|PCI|PREF, 1, 1, 0, 0, 1, 0);
        run_check("R6 fetch no exec", LEAF|PR|PW|PREF, 1, 1, 0, 0, 1, 0);
    endtask

    task automatic t_rc();
        run_check("R7 load no ref", LEAF|PR, 0, 0, 0, 0, 0, 1);
        run_check("R7 store no change", LEAF|PW|PREF, 0, 0, 1, 0, 0, 1);
        run_check("R7 load no change", LEAF|PR|PREF, 0, 0, 0, 1, 0, 0);
        run_check("R7 fetch no ref", LEAF|PX, 0, 1, 0, 0, 0, 1);
    endtask

    task automatic t_prec();
        run_check("R8 both fail store", LEAF|PR, 0, 0, 1, 0, 1, 0);
        run_check("R8 both fail fetch", LEAF|PCI|PX, 0, 1, 0, 0, 1, 0);
        run_check("R9 all pass", LEAF|PX|PW|PR|PREF|PC, 1, 0, 1, 1, 0, 0);
    endtask

    task automatic t_hold();
        run_check("R10 setup", LEAF|PR, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pte_i = LEAF|PW|PREF|PC; priv_i = i[0]; ifetch_i = 1'b0; store_i = i[1];
        end
        @(negedge clk);
        expect4("R10 idle hold", {rdy_o, go_o, perm_fault_o, rc_fault_o}, 4'b0001);
        run_check("R10 next request", LEAF|PW|PREF|PC, 0, 0, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_nonleaf();
        t_priv();
        t_data();
        t_fetch();
        t_rc();
        t_prec();
        t_hold();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule